// File: doc/BRIEF.md
# UART Control and Status Register Front End

This block is the software-visible face of a serial port. It sits on a simple 32-bit bus that carries a byte offset inside a 4 KB window, with one access per cycle. It keeps the configuration registers: the baud divisors, the low-power divisor, line and port control, the receive level select and the DMA control. It also holds the interrupt state, which is a raw status word, an enable mask and a write-one-to-clear port. A single interrupt line is high while any enabled raw bit is set. The top eight words of the window return fixed identification bytes.

The block does not serialize data and does not store FIFO contents. A write to the data word offers the low byte to the transmitter on a valid/ready stream. `tx_valid` rises in the cycle after the write and stays high, with `tx_data` unchanged, until a cycle in which `tx_ready` is also high. A data write that arrives while an earlier byte is still waiting is dropped. A write in the cycle in which the handshake completes is accepted. On the receive side, an external FIFO presents its head byte and its fill level. A read of the data word returns the head byte and, when the level is nonzero, pulses `rx_pop` for that cycle. The FIFO must apply the pop before the following clock edge.

Top module: `uart_csr`

## Requirements
- R1: After reset, every configuration register, the raw status and the mask read zero. The flag word reads 0x90 while `tx_fifo_empty`=1, `tx_fifo_full`=0 and `rx_level`=0, and `irq` is low.
- R2: Word indices are the byte offset divided by 4. Configuration registers read back what was written, truncated to their widths: word 8 is 8 bits, 9 is 16, 10 is 6, 11 is 8, 12 is 16, 13 is 6, 14 (mask) is 11 and 18 is 3.
- R3: Byte offsets 0xFE0 to 0xFFC read, one per word in rising order, 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R4: Words 1 to 5, 7 and 19 and above outside the identification window read zero. Writes to those words, to the raw (15) and masked (16) status words and to the identification window change nothing.
- R5: A write to word 0 presents bits 7:0 on `tx_data` with `tx_valid` high from the next cycle, held until `tx_ready`. The write also sets raw bit 5.
- R6: A data write while a byte waits without `tx_ready` is dropped. Flag bit 5 reads 1 while a byte waits or `tx_fifo_full` is 1. Flag bit 7 reads 1 only when `tx_fifo_empty` is 1 and no byte waits.
- R7: A read of word 0 returns `rx_head` in bits 7:0 and pulses `rx_pop` in the same cycle when `rx_level` is nonzero. There is no pulse when the level is zero.
- R8: Flag bit 4 is 1 when `rx_level` is 0. Flag bit 6 is 1 when `rx_level` equals DEPTH while FIFO mode (word 11 bit 4) is on, or when `rx_level` is nonzero while FIFO mode is off. Writes to word 6 have no effect.
- R9: The receive trigger is 1 when FIFO mode is off. When FIFO mode is on, it is 4 times word 13 bits 5:3, with 0 replaced by 1. Raw bit 4 is set at the clock edge where `rx_level` has risen to equal the trigger.
- R10: Raw bit 4 is cleared at the clock edge where `rx_level` has fallen to one below the trigger.
- R11: `irq` is high exactly when raw AND mask is nonzero, and word 16 reads that AND.
- R12: A write to word 17 clears each raw bit that is written as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_data | output | 8 | Transmit byte |
| tx_fifo_empty | input | 1 | Transmit path fully drained |
| tx_fifo_full | input | 1 | Transmit path cannot accept more |
| rx_head | input | 8 | Oldest received byte |
| rx_level | input | 5 | Receive fill level, 0 to DEPTH |
| rx_pop | output | 1 | Removes the head byte at this edge |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `rx_level` never exceeds DEPTH, that it follows each `rx_pop` before the next edge, and that it moves by at most one per cycle, so every crossing of the trigger is seen as a single step. They also assume that the bus makes at most one access per cycle. The bench models the receive FIFO itself. It changes the level one step at a time between edges and pops only on the pulse it observed. It never fills the model past DEPTH.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
  localparam int BUS_W  = 32;
  localparam int OFS_W  = 12;
  localparam int WIDX_W = OFS_W - 2;

  localparam logic [WIDX_W-1:0] WI_DATA  = WIDX_W'(0);
  localparam logic [WIDX_W-1:0] WI_FLAG  = WIDX_W'(6);
  localparam logic [WIDX_W-1:0] WI_LPDIV = WIDX_W'(8);
  localparam logic [WIDX_W-1:0] WI_IBAUD = WIDX_W'(9);
  localparam logic [WIDX_W-1:0] WI_FBAUD = WIDX_W'(10);
  localparam logic [WIDX_W-1:0] WI_LINE  = WIDX_W'(11);
  localparam logic [WIDX_W-1:0] WI_CTRL  = WIDX_W'(12);
  localparam logic [WIDX_W-1:0] WI_LSEL  = WIDX_W'(13);
  localparam logic [WIDX_W-1:0] WI_MASK  = WIDX_W'(14);
  localparam logic [WIDX_W-1:0] WI_RAW   = WIDX_W'(15);
  localparam logic [WIDX_W-1:0] WI_MIS   = WIDX_W'(16);
  localparam logic [WIDX_W-1:0] WI_CLR   = WIDX_W'(17);
  localparam logic [WIDX_W-1:0] WI_DMA   = WIDX_W'(18);

  localparam int LPDIV_W = 8;
  localparam int IBAUD_W = 16;
  localparam int FBAUD_W = 6;
  localparam int LINE_W  = 8;
  localparam int CTRL_W  = 16;
  localparam int LSEL_W  = 6;
  localparam int IRQ_W   = 11;
  localparam int DMA_W   = 3;
  localparam int CHAR_W  = 8;
  localparam int TRIG_W  = 6;

  localparam int RX_BIT      = 4;
  localparam int TX_BIT      = 5;
  localparam int FIFO_EN_BIT = 4;

  localparam int FL_RXE = 4;
  localparam int FL_TXF = 5;
  localparam int FL_RXF = 6;
  localparam int FL_TXE = 7;

  function automatic logic [7:0] ident_byte(input logic [2:0] k);
    logic [7:0] b;
    case (k)
      3'd0:    b = 8'h11;
      3'd1:    b = 8'h10;
      3'd2:    b = 8'h14;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/uart_csr_trigger.sv
module uart_csr_trigger
  import uart_csr_pkg::*;
(
  input  logic [LINE_W-1:0] line_cfg,
  input  logic [LSEL_W-1:0] level_sel,
  output logic [TRIG_W-1:0] trig
);
  logic [TRIG_W-1:0] scaled;

  // the select field picks a multiple of four entries
  assign scaled = TRIG_W'({level_sel[LSEL_W-1:LSEL_W-3], 2'b00});

  always_comb begin
    if (!line_cfg[FIFO_EN_BIT] || scaled == '0) trig = TRIG_W'(1);
    else                                        trig = scaled;
  end
endmodule

// File: rtl/uart_csr_irq.sv
module uart_csr_irq
  import uart_csr_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_tx,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [TRIG_W-1:0] trig,
  input  logic              mask_we,
  input  logic              clr_we,
  input  logic [IRQ_W-1:0]  wbits,
  output logic [IRQ_W-1:0]  raw,
  output logic [IRQ_W-1:0]  mask,
  output logic              irq
);
  logic [LVL_W-1:0]  prev_level;
  logic [TRIG_W-1:0] lvl_ext;
  logic              rx_up, rx_down;
  logic [IRQ_W-1:0]  raw_n;

  assign lvl_ext = TRIG_W'(rx_level);
  assign rx_up   = (rx_level > prev_level) && (lvl_ext == trig);
  assign rx_down = (rx_level < prev_level) && (lvl_ext == trig - TRIG_W'(1));

  always_comb begin
    raw_n = raw;
    if (clr_we)  raw_n = raw_n & ~wbits;
    if (rx_down) raw_n[RX_BIT] = 1'b0;
    // events of this cycle win over a clear of the same cycle
    if (rx_up)   raw_n[RX_BIT] = 1'b1;
    if (set_tx)  raw_n[TX_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw        <= '0;
      mask       <= '0;
      prev_level <= '0;
    end else begin
      raw        <= raw_n;
      prev_level <= rx_level;
      if (mask_we) mask <= wbits;
    end
  end

  assign irq = |(raw & mask);

  a_r5_tx_raise: assert property (@(posedge clk) disable iff (!rst_n)
    set_tx |=> raw[TX_BIT]);

  a_r9_rx_raise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_up |=> raw[RX_BIT]);

  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_tx && !rx_up) |=> ((raw & $past(wbits)) == '0));
endmodule

// File: rtl/uart_csr_txport.sv
module uart_csr_txport
  import uart_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_char,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [CHAR_W-1:0] tx_data,
  output logic              waiting
);
  logic take;

  // a new byte is taken only when the slot is free or being emptied now
  assign take    = load && (!tx_valid || tx_ready);
  assign waiting = tx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (take) begin
      tx_valid <= 1'b1;
      tx_data  <= load_char;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  a_r5_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/uart_csr.sv
module uart_csr
  import uart_csr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [CHAR_W-1:0] tx_data,
  input  logic              tx_fifo_empty,
  input  logic              tx_fifo_full,
  input  logic [CHAR_W-1:0] rx_head,
  input  logic [LVL_W-1:0]  rx_level,
  output logic              rx_pop,
  output logic              irq
);
  logic [WIDX_W-1:0]  widx;
  logic               wr_en, rd_en, in_ident;
  logic [LPDIV_W-1:0] lpdiv_q;
  logic [IBAUD_W-1:0] ibaud_q;
  logic [FBAUD_W-1:0] fbaud_q;
  logic [LINE_W-1:0]  line_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [LSEL_W-1:0]  lsel_q;
  logic [DMA_W-1:0]   dma_q;
  logic [TRIG_W-1:0]  trig;
  logic [IRQ_W-1:0]   raw, mask;
  logic               tx_waiting, rx_full_flag;
  logic [7:0]         flags;
  logic               unused_bits;

  assign widx     = bus_addr[OFS_W-1:2];
  assign wr_en    = bus_sel && bus_wr;
  assign rd_en    = bus_sel && !bus_wr;
  assign in_ident = (bus_addr[OFS_W-1:5] == '1);
  assign unused_bits = ^{bus_wdata[BUS_W-1:CTRL_W], bus_addr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpdiv_q <= '0;
      ibaud_q <= '0;
      fbaud_q <= '0;
      line_q  <= '0;
      ctrl_q  <= '0;
      lsel_q  <= '0;
      dma_q   <= '0;
    end else if (wr_en) begin
      case (widx)
        WI_LPDIV: lpdiv_q <= bus_wdata[LPDIV_W-1:0];
        WI_IBAUD: ibaud_q <= bus_wdata[IBAUD_W-1:0];
        WI_FBAUD: fbaud_q <= bus_wdata[FBAUD_W-1:0];
        WI_LINE:  line_q  <= bus_wdata[LINE_W-1:0];
        WI_CTRL:  ctrl_q  <= bus_wdata[CTRL_W-1:0];
        WI_LSEL:  lsel_q  <= bus_wdata[LSEL_W-1:0];
        WI_DMA:   dma_q   <= bus_wdata[DMA_W-1:0];
        default: ;
      endcase
    end
  end

  uart_csr_trigger u_trig (
    .line_cfg  (line_q),
    .level_sel (lsel_q),
    .trig      (trig)
  );

  uart_csr_irq #(.LVL_W(LVL_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_tx   (wr_en && widx == WI_DATA),
    .rx_level (rx_level),
    .trig     (trig),
    .mask_we  (wr_en && widx == WI_MASK),
    .clr_we   (wr_en && widx == WI_CLR),
    .wbits    (bus_wdata[IRQ_W-1:0]),
    .raw      (raw),
    .mask     (mask),
    .irq      (irq)
  );

  uart_csr_txport u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_en && widx == WI_DATA),
    .load_char (bus_wdata[CHAR_W-1:0]),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .waiting   (tx_waiting)
  );

  assign rx_full_flag = line_q[FIFO_EN_BIT] ? (rx_level == LVL_W'(DEPTH))
                                            : (rx_level != '0);

  always_comb begin
    flags         = '0;
    flags[FL_TXE] = tx_fifo_empty && !tx_waiting;
    flags[FL_RXF] = rx_full_flag;
    flags[FL_TXF] = tx_fifo_full || tx_waiting;
    flags[FL_RXE] = (rx_level == '0);
  end

  assign rx_pop = rd_en && (widx == WI_DATA) && (rx_level != '0);

  always_comb begin
    bus_rdata = '0;
    if (in_ident) begin
      bus_rdata[7:0] = ident_byte(bus_addr[4:2]);
    end else begin
      case (widx)
        WI_DATA:  bus_rdata[CHAR_W-1:0]  = rx_head;
        WI_FLAG:  bus_rdata[7:0]         = flags;
        WI_LPDIV: bus_rdata[LPDIV_W-1:0] = lpdiv_q;
        WI_IBAUD: bus_rdata[IBAUD_W-1:0] = ibaud_q;
        WI_FBAUD: bus_rdata[FBAUD_W-1:0] = fbaud_q;
        WI_LINE:  bus_rdata[LINE_W-1:0]  = line_q;
        WI_CTRL:  bus_rdata[CTRL_W-1:0]  = ctrl_q;
        WI_LSEL:  bus_rdata[LSEL_W-1:0]  = lsel_q;
        WI_MASK:  bus_rdata[IRQ_W-1:0]   = mask;
        WI_RAW:   bus_rdata[IRQ_W-1:0]   = raw;
        WI_MIS:   bus_rdata[IRQ_W-1:0]   = raw & mask;
        WI_DMA:   bus_rdata[DMA_W-1:0]   = dma_q;
        default: ;
      endcase
    end
  end

  a_r11_mis_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_ident && widx == WI_MIS) |-> ((bus_rdata != '0) == irq));
endmodule

// File: tb/uart_csr_test.sv
module uart_csr_test;
  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_empty = 1'b1, tx_full = 1'b0;
  logic [7:0]  rx_head;
  logic [4:0]  lvl = '0;
  logic [3:0]  hd = '0;
  logic [7:0]  fmem [16];
  logic        rx_pop, irq;
  int          checks = 0, errors = 0;

  always #(CLK_T/2) clk = ~clk;
  assign rx_head = fmem[hd];

  uart_csr uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_fifo_empty(tx_empty),
    .tx_fifo_full(tx_full), .rx_head(rx_head), .rx_level(lvl),
    .rx_pop(rx_pop), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input int word, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = 12'(word * 4); wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bread(input int word, output logic [31:0] d, output logic popped);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = 12'(word * 4);
    #1; d = rdata; popped = rx_pop;
    @(posedge clk); #1;
    sel = 1'b0;
    if (popped) begin hd = hd + 4'd1; lvl = lvl - 5'd1; end
  endtask

  task automatic rchk(input string req, input int word, input logic [31:0] exp);
    logic [31:0] d; logic p;
    bread(word, d, p);
    chk(req, d, exp);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    fmem[hd + lvl[3:0]] = d;
    lvl = lvl + 5'd1;
  endtask

  function automatic int wbits(input int idx);
    case (idx)
      8: return 8;   9: return 16; 10: return 6; 11: return 8;
      12: return 16; 13: return 6; 14: return 11; default: return 3;
    endcase
  endfunction

  initial begin
    #(CLK_T * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int regs [8] = '{8, 9, 10, 11, 12, 13, 14, 18};
    logic [31:0] pats [4] = '{32'hFFFFFFFF, 32'hA5A5A5A5, 32'h5A5A5A5A, 32'h0};
    logic [7:0] idb [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    logic [31:0] d;
    logic p;
    for (int i = 0; i < 16; i++) fmem[i] = 8'(i * 7 + 3);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rchk("R1 flag", 6, 32'h90);
    rchk("R1 raw", 15, 0);
    foreach (regs[i]) rchk("R1 cfg", regs[i], 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);

    // R2 read back truncated to width
    foreach (pats[j]) foreach (regs[i]) begin
      bwrite(regs[i], pats[j]);
      rchk("R2 readback", regs[i], pats[j] & ((32'd1 << wbits(regs[i])) - 1));
    end

    // R4 unmapped and read-only words ignore writes and read zero
    for (int w = 1; w < 64; w++)
      if (w < 6 || w == 7 || w == 15 || w == 16 || w >= 19) bwrite(w, 32'hFFFFFFFF);
    for (int w = 1016; w < 1024; w++) bwrite(w, 32'hFFFFFFFF);
    foreach (regs[i]) rchk("R4 cfg untouched", regs[i], 0);
    rchk("R4 raw untouched", 15, 0);
    chk("R4 irq", {31'b0, irq}, 0);
    for (int w = 1; w < 64; w++)
      if (w < 6 || w == 7 || w >= 19) rchk("R4 unmapped read", w, 0);

    // R8 flag word ignores writes
    bwrite(6, 32'hFFFFFFFF);
    rchk("R8 flag write ignored", 6, 32'h90);

    // R3 identification bytes
    for (int k = 0; k < 8; k++) rchk("R3 ident", 1016 + k, {24'b0, idb[k]});

    // R5 and R6 transmit stream
    bwrite(0, 32'h000001C3);
    chk("R5 tx_valid", {31'b0, tx_valid}, 1);
    chk("R5 tx_data", {24'b0, tx_data}, 32'hC3);
    rchk("R5 raw tx bit", 15, 32'h20);
    rchk("R6 flag while waiting", 6, 32'h30);
    bwrite(0, 32'h55);
    chk("R6 dropped write keeps data", {24'b0, tx_data}, 32'hC3);
    chk("R6 still valid", {31'b0, tx_valid}, 1);
    @(negedge clk); tx_ready = 1'b1;
    @(posedge clk); #1;
    chk("R5 handshake ends valid", {31'b0, tx_valid}, 0);
    @(negedge clk); tx_full = 1'b1; tx_empty = 1'b0;
    #1; rchk("R6 flag tx full", 6, 32'h30);
    @(negedge clk); tx_full = 1'b0; tx_empty = 1'b1;
    rchk("R6 flag idle", 6, 32'h90);

    // R12 write-one-to-clear
    bwrite(17, 32'h10);
    rchk("R12 other bit kept", 15, 32'h20);
    bwrite(17, 32'h20);
    rchk("R12 cleared", 15, 0);

    // R11 masking
    bwrite(14, 32'h20);
    bwrite(0, 32'h7A);
    chk("R11 irq on", {31'b0, irq}, 1);
    rchk("R11 masked status", 16, 32'h20);
    bwrite(14, 32'h10);
    chk("R11 irq masked off", {31'b0, irq}, 0);
    rchk("R11 masked status zero", 16, 0);
    bwrite(17, 32'h7FF);
    bwrite(14, 0);

    // R7 receive pops
    push(8'h3A); push(8'h7E);
    bread(0, d, p);
    chk("R7 head byte", d, 32'h3A); chk("R7 pop pulse", {31'b0, p}, 1);
    bread(0, d, p);
    chk("R7 second byte", d, 32'h7E); chk("R7 pop pulse", {31'b0, p}, 1);
    bread(0, d, p);
    chk("R7 no pop when empty", {31'b0, p}, 0);
    bwrite(17, 32'h7FF);

    // R9 and R10 trigger with FIFO mode, select 1 gives 4
    bwrite(11, 32'h10); bwrite(13, 32'h08);
    push(8'h01); push(8'h02); push(8'h03);
    rchk("R9 below trigger", 15, 0);
    push(8'h04);
    rchk("R9 reached trigger", 15, 32'h10);
    bread(0, d, p);
    chk("R7 fifo order", d, 32'h01);
    @(posedge clk);
    rchk("R10 fell below trigger", 15, 0);
    // R8 full in FIFO mode
    while (lvl < 16) push(8'hEE);
    rchk("R8 full flag fifo mode", 6, 32'hC0);
    @(negedge clk); lvl = 0; hd = 0;
    bwrite(17, 32'h7FF);

    // R9 select zero in FIFO mode behaves as 1
    bwrite(13, 0);
    push(8'h09);
    rchk("R9 zero select trigger 1", 15, 32'h10);
    @(negedge clk); lvl = 0;
    bwrite(17, 32'h7FF);

    // R9 FIFO mode off gives trigger 1; R8 full at one entry
    bwrite(11, 0); bwrite(13, 32'h38);
    push(8'h42);
    rchk("R9 non-fifo trigger", 15, 32'h10);
    rchk("R8 full flag single", 6, 32'hC0);
    bread(0, d, p);
    @(posedge clk);
    rchk("R10 clear at zero", 15, 0);
    rchk("R8 empty flag", 6, 32'h90);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule